// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the datapath of a 32-bit processor that runs each instruction over several clock cycles and handles five instruction classes: word load, word store, register-register arithmetic, branch on equality and unconditional jump. It holds the program counter, an instruction latch, a memory data latch, two operand latches, an ALU result latch and a 32-entry register file. A single memory port serves both instruction fetch and data access.

The block makes no decisions of its own. An external sequencer drives every select and every write enable once per cycle and reads back the opcode field. Because the intermediate latches carry values from one cycle to the next, each step of an instruction (fetch, decode, execute, memory, write-back) fits in exactly one clock. A load takes five cycles, a store or ALU operation four, and a branch or jump three. Memory is read combinationally: the word at `mem_addr` appears on `mem_rdata` in the same cycle.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, the program counter and every internal latch are cleared, so `pc_out` reads 0.
- R2: `mem_addr` is the word address (byte address bits [ADDR_W+1:2]) of the program counter when `addr_sel`=0 and of the ALU result latch when `addr_sel`=1; `mem_wdata` is the B operand latch; `mem_re`/`mem_we` follow `mem_rd`/`mem_wr`.
- R3: The program counter loads when `pc_load` is high, or when `pc_load_if_zero` is high and the ALU result is zero. Its source is chosen by `pc_src`: 0 the live ALU result, 1 the ALU result latch, 2 the jump target {PC[31:28], IR[25:0], 2'b00}.
- R4: ALU input A is the PC when `srca_sel`=0 and the A latch when 1. Input B is chosen by `srcb_sel`: 0 the B latch, 1 the constant 4, 2 the sign-extended IR[15:0], 3 the sign-extended IR[15:0] shifted left by 2.
- R5: `alu_mode` 0 adds, 1 subtracts, 2 decodes IR[5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0); any other code in mode 2, and mode 3, adds.
- R6: The instruction latch loads `mem_rdata` only in a cycle with `ir_load` high and otherwise holds; `instr_op` shows its bits [31:26].
- R7: The memory data latch and the ALU result latch load on every clock with no enable; the A and B latches load every clock from the registers named by IR[25:21] and IR[20:16].
- R8: With `reg_we` high, the register file writes the register named by IR[15:11] when `dst_sel_rd`=1 or IR[20:16] when 0, with the ALU result latch when `wb_sel_mem`=0 or the memory data latch when 1.
- R9: Register 0 always reads as zero; a write to it has no effect.
- R10: A branch target computed as PC + (sign-extended IR[15:0] << 2) during decode is taken into the PC on a conditional load only when the two compared registers are equal, for forward and backward offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_sel | input | 1 | Memory address source: 0 PC, 1 ALU result latch |
| mem_rd | input | 1 | Memory read strobe request |
| mem_wr | input | 1 | Memory write strobe request |
| ir_load | input | 1 | Instruction latch load enable |
| pc_load | input | 1 | Unconditional PC load |
| pc_load_if_zero | input | 1 | PC load when ALU result is zero |
| pc_src | input | 2 | PC source select |
| srca_sel | input | 1 | ALU input A select |
| srcb_sel | input | 2 | ALU input B select |
| alu_mode | input | 2 | ALU operation mode |
| reg_we | input | 1 | Register file write enable |
| dst_sel_rd | input | 1 | Write destination: 1 IR[15:11], 0 IR[20:16] |
| wb_sel_mem | input | 1 | Write data: 1 memory data latch, 0 ALU result latch |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| pc_out | output | 32 | Program counter |
| instr_op | output | 6 | Opcode field of the instruction latch |

## Verification
The bench acts as the sequencer and steps real instruction sequences, checking results through stores to its memory model and through `pc_out`. Set-less-than is tested with mixed signs and with equal operands; an unsigned compare or a `<=` would flip those results. A negative load offset catches a zero-extended immediate, a backward branch catches a missing sign extension on the shifted offset, and a not-taken branch catches a PC that loads whatever the zero flag says. An instruction word placed at the next PC during decode would replace the running instruction if the instruction latch loaded without its enable. Writes aimed at register 0 and at rd with a distinct rt reveal a writable zero register or a swapped destination select.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);
    localparam int IMM_W  = 16;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_FN  = 2'b10,
        ALU_RSV = 2'b11
    } alu_mode_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] mdr;
        logic [XLEN-1:0] alu_out;
    } dp_state_t;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alu_mode_e    mode,
    input  logic [5:0]   funct,
    output logic [W-1:0] res,
    output logic         zero
);
    typedef enum logic [2:0] {K_ADD, K_SUB, K_AND, K_OR, K_SLT} kind_e;

    kind_e        kind;
    logic [W-1:0] sum;
    logic [W-1:0] diff;
    logic         less;

    always_comb begin
        kind = K_ADD;
        case (mode)
            ALU_SUB: kind = K_SUB;
            ALU_FN: begin
                case (funct)
                    FN_SUB:  kind = K_SUB;
                    FN_AND:  kind = K_AND;
                    FN_OR:   kind = K_OR;
                    FN_SLT:  kind = K_SLT;
                    default: kind = K_ADD;
                endcase
            end
            default: kind = K_ADD;
        endcase
    end

    assign sum  = opa + opb;
    assign diff = opa - opb;
    assign less = $signed(opa) < $signed(opb);

    always_comb begin
        case (kind)
            K_SUB:   res = diff;
            K_AND:   res = opa & opb;
            K_OR:    res = opa | opb;
            K_SLT:   res = {{(W-1){1'b0}}, less};
            default: res = sum;
        endcase
    end

    assign zero = (res == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              ir_load,
    input  logic              pc_load,
    input  logic              pc_load_if_zero,
    input  logic [1:0]        pc_src,
    input  logic              srca_sel,
    input  logic [1:0]        srcb_sel,
    input  logic [1:0]        alu_mode,
    input  logic              reg_we,
    input  logic              dst_sel_rd,
    input  logic              wb_sel_mem,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              mem_re,
    output logic              mem_we,
    output logic [XLEN-1:0]   pc_out,
    output logic [5:0]        instr_op
);
    localparam int JUMP_W = 26;
    localparam int SEG_W  = XLEN - JUMP_W - 2;

    dp_state_t st_d, st_q;

    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   alu_a, alu_b, alu_res;
    logic              alu_zero;
    logic [XLEN-1:0]   jump_tgt;
    logic              pc_en;
    logic [RIDX_W-1:0] wr_idx;
    logic [XLEN-1:0]   wr_data;
    logic [XLEN-1:0]   rf_a, rf_b;

    // Signals brought out for the bound checker
    logic [XLEN-1:0] ir_q, a_q, mdr_q;
    assign ir_q  = st_q.ir;
    assign a_q   = st_q.a;
    assign mdr_q = st_q.mdr;

    mc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk     (clk),
        .we      (reg_we),
        .waddr   (wr_idx),
        .wdata   (wr_data),
        .raddr_a (st_q.ir[25:21]),
        .raddr_b (st_q.ir[20:16]),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    mc_alu #(.W(XLEN)) u_alu (
        .opa   (alu_a),
        .opb   (alu_b),
        .mode  (alu_mode_e'(alu_mode)),
        .funct (st_q.ir[5:0]),
        .res   (alu_res),
        .zero  (alu_zero)
    );

    // Operand, target and write-back selection
    always_comb begin
        imm_ext  = {{(XLEN-IMM_W){st_q.ir[IMM_W-1]}}, st_q.ir[IMM_W-1:0]};
        jump_tgt = {st_q.pc[XLEN-1 -: SEG_W], st_q.ir[JUMP_W-1:0], 2'b00};
        alu_a    = srca_sel ? st_q.a : st_q.pc;
        case (srcb_sel)
            2'd0:    alu_b = st_q.b;
            2'd1:    alu_b = XLEN'(4);
            2'd2:    alu_b = imm_ext;
            default: alu_b = {imm_ext[XLEN-3:0], 2'b00};
        endcase
        wr_idx  = dst_sel_rd ? st_q.ir[15:11] : st_q.ir[20:16];
        wr_data = wb_sel_mem ? st_q.mdr : st_q.alu_out;
        pc_en   = pc_load | (pc_load_if_zero & alu_zero);
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;
        if (pc_en) begin
            case (pc_src)
                2'd1:    st_d.pc = st_q.alu_out;
                2'd2:    st_d.pc = jump_tgt;
                default: st_d.pc = alu_res;
            endcase
        end
        if (ir_load) begin
            st_d.ir = mem_rdata;
        end
        st_d.a       = rf_a;
        st_d.b       = rf_b;
        st_d.mdr     = mem_rdata;
        st_d.alu_out = alu_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = addr_sel ? st_q.alu_out[ADDR_W+1:2] : st_q.pc[ADDR_W+1:2];
    assign mem_wdata = st_q.b;
    assign mem_re    = mem_rd;
    assign mem_we    = mem_wr;
    assign pc_out    = st_q.pc;
    assign instr_op  = st_q.ir[XLEN-1:XLEN-6];
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk
    import mc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            pc_load,
    input logic            pc_load_if_zero,
    input logic [1:0]      pc_src,
    input logic            srca_sel,
    input logic [1:0]      srcb_sel,
    input logic [1:0]      alu_mode,
    input logic            ir_load,
    input logic [XLEN-1:0] mem_rdata,
    input logic [XLEN-1:0] pc_out,
    input logic [XLEN-1:0] ir_q,
    input logic [XLEN-1:0] a_q,
    input logic [XLEN-1:0] mdr_q
);
    // R3
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_load && !pc_load_if_zero) |=> $stable(pc_out));

    // R3 R4
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && pc_src == 2'd0 && !srca_sel && srcb_sel == 2'd1 && alu_mode == 2'd0)
        |=> (pc_out == $past(pc_out) + 32'd4));

    // R3
    jump_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && pc_src == 2'd2)
        |=> (pc_out[31:28] == $past(pc_out[31:28]) && pc_out[1:0] == 2'b00));

    // R6
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_load |=> $stable(ir_q));

    // R7
    mdr_every_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mdr_q == $past(mem_rdata)));

    // R9
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q[25:21] == 5'd0) |=> (a_q == '0));
endmodule

bind mc_datapath mc_datapath_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .pc_load         (pc_load),
    .pc_load_if_zero (pc_load_if_zero),
    .pc_src          (pc_src),
    .srca_sel        (srca_sel),
    .srcb_sel        (srcb_sel),
    .alu_mode        (alu_mode),
    .ir_load         (ir_load),
    .mem_rdata       (mem_rdata),
    .pc_out          (pc_out),
    .ir_q            (ir_q),
    .a_q             (a_q),
    .mdr_q           (mdr_q)
);

// File: tb/tb_mc_datapath.sv
`timescale 1ns/1ps
module tb_mc_datapath;
    localparam int ADDR_W = 8;
    localparam int MWORDS = 1 << ADDR_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_sel, mem_rd, mem_wr, ir_load, pc_load, pc_load_if_zero;
    logic [1:0]  pc_src, srcb_sel, alu_mode;
    logic        srca_sel, reg_we, dst_sel_rd, wb_sel_mem;
    logic [31:0] mem_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata, pc_out;
    logic        mem_re, mem_we;
    logic [5:0]  instr_op;

    logic [31:0] mem [MWORDS];
    int          n_chk = 0;
    int          n_err = 0;
    logic [ADDR_W-1:0] cap_addr;
    logic [5:0]  last_op;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    mc_datapath #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ir_load(ir_load), .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
        .pc_src(pc_src), .srca_sel(srca_sel), .srcb_sel(srcb_sel), .alu_mode(alu_mode),
        .reg_we(reg_we), .dst_sel_rd(dst_sel_rd), .wb_sel_mem(wb_sel_mem),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_we(mem_we), .pc_out(pc_out), .instr_op(instr_op)
    );

    // {operand a, operand b, funct, expected}
    localparam logic [101:0] VEC [8] = '{
        {32'd7,         32'd5,         6'h20, 32'd12},
        {32'd5,         32'd7,         6'h22, 32'hFFFF_FFFE},
        {32'hF0F0_1234, 32'h0FF0_FF00, 6'h24, 32'h00F0_1200},
        {32'hF000_0000, 32'h0000_000F, 6'h25, 32'hF000_000F},
        {32'hFFFF_FFFD, 32'd2,         6'h2A, 32'd1},
        {32'd2,         32'hFFFF_FFFD, 6'h2A, 32'd0},
        {32'd5,         32'd5,         6'h2A, 32'd0},
        {32'd1,         32'd2,         6'h27, 32'd3}
    };

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        addr_sel = 0; mem_rd = 0; mem_wr = 0; ir_load = 0; pc_load = 0; pc_load_if_zero = 0;
        pc_src = 0; srca_sel = 0; srcb_sel = 0; alu_mode = 0; reg_we = 0; dst_sel_rd = 0; wb_sel_mem = 0;
    endtask

    // Called at a negedge with controls set; returns at the next negedge.
    task automatic tick();
        logic we_s;
        logic [ADDR_W-1:0] a_s;
        logic [31:0] d_s;
        #1;
        we_s = mem_we; a_s = mem_addr; d_s = mem_wdata;
        @(posedge clk);
        @(negedge clk);
        if (we_s) begin
            mem[a_s] = d_s;
            cap_addr = a_s;
        end
    endtask

    task automatic run(input logic [31:0] instr);
        mem[pc_out[ADDR_W+1:2]] = instr;
        clr(); mem_rd = 1; ir_load = 1; srcb_sel = 2'd1; pc_load = 1; tick();
        last_op = instr_op;
        clr(); srcb_sel = 2'd3; tick();
        case (instr[31:26])
            6'h23: begin
                clr(); srca_sel = 1; srcb_sel = 2'd2; tick();
                clr(); addr_sel = 1; mem_rd = 1; tick();
                clr(); reg_we = 1; wb_sel_mem = 1; tick();
            end
            6'h2B: begin
                clr(); srca_sel = 1; srcb_sel = 2'd2; tick();
                clr(); addr_sel = 1; mem_wr = 1; tick();
            end
            6'h00: begin
                clr(); srca_sel = 1; alu_mode = 2'd2; tick();
                clr(); reg_we = 1; dst_sel_rd = 1; tick();
            end
            6'h04: begin
                clr(); srca_sel = 1; alu_mode = 2'd1; pc_load_if_zero = 1; pc_src = 2'd1; tick();
            end
            default: begin
                clr(); pc_load = 1; pc_src = 2'd2; tick();
            end
        endcase
        clr();
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] p;
        logic [31:0] va, vb, ve;
        logic [5:0]  fn;
        for (int i = 0; i < MWORDS; i++) mem[i] = '0;
        clr();
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state, R2 address from PC
        chk(pc_out == 32'd0, "R1 pc after reset", pc_out, 32'd0);
        chk(mem_addr == '0, "R2 fetch address at reset", 32'(mem_addr), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R5 ALU function decode, R7/R8 load and write-back
        for (int i = 0; i < 8; i++) begin
            {va, vb, fn, ve} = VEC[i];
            mem[200] = va;
            mem[201] = vb;
            run(enc_i(6'h23, 0, 1, 800));
            if (i == 0) chk(pc_out == 32'd4, "R3 pc plus four after fetch", pc_out, 32'd4);
            run(enc_i(6'h23, 0, 2, 804));
            run(enc_r(1, 2, 3, fn));
            run(enc_i(6'h2B, 0, 3, 808));
            chk(mem[202] == ve, $sformatf("R5 alu vector %0d", i), mem[202], ve);
        end
        // R2 store address from ALU result latch
        chk(cap_addr == 8'd202, "R2 store word address", 32'(cap_addr), 32'd202);
        // R6 opcode output
        chk(last_op == 6'h2B, "R6 opcode field", 32'(last_op), 32'h2B);

        // R4 negative immediate offset
        mem[204] = 32'h0000_0340;
        mem[205] = 32'hCAFE_F00D;
        run(enc_i(6'h23, 0, 4, 816));
        run(enc_i(6'h23, 4, 5, -12));
        run(enc_i(6'h2B, 0, 5, 824));
        chk(mem[206] == 32'hCAFE_F00D, "R4 negative offset load", mem[206], 32'hCAFE_F00D);

        // R9 write to register 0 ignored
        run(enc_r(4, 5, 0, 6'h20));
        mem[207] = 32'hDEAD_BEEF;
        run(enc_i(6'h2B, 0, 0, 828));
        chk(mem[207] == 32'd0, "R9 register zero stays zero", mem[207], 32'd0);

        // R8 destination select rd versus rt
        mem[209] = 32'h0000_0011;
        run(enc_i(6'h23, 0, 7, 836));
        run(enc_r(5, 0, 8, 6'h20) | 32'h0007_0000 & 32'h0000_0000);
        run(enc_r(0, 5, 8, 6'h20));
        run(enc_i(6'h2B, 0, 7, 840));
        run(enc_i(6'h2B, 0, 8, 844));
        chk(mem[210] == 32'h11, "R8 rt untouched by rd write", mem[210], 32'h11);
        chk(mem[211] == 32'hCAFE_F00D, "R8 rd written", mem[211], 32'hCAFE_F00D);

        // R6 instruction latch holds while the next word differs
        p = pc_out;
        mem[p[ADDR_W+1:2] + 1] = enc_r(1, 2, 10, 6'h22);
        run(enc_r(1, 2, 10, 6'h20));
        run(enc_i(6'h2B, 0, 10, 848));
        chk(mem[212] == 32'd3, "R6 latch holds instruction", mem[212], 32'd3);

        // R10 branch taken forward, not taken, taken backward
        p = pc_out;
        run(enc_i(6'h04, 1, 1, 3));
        chk(pc_out == p + 32'd16, "R10 branch taken forward", pc_out, p + 32'd16);
        p = pc_out;
        run(enc_i(6'h04, 1, 2, 3));
        chk(pc_out == p + 32'd4, "R10 branch not taken", pc_out, p + 32'd4);
        p = pc_out;
        run(enc_i(6'h04, 2, 2, -2));
        chk(pc_out == p - 32'd4, "R10 branch taken backward", pc_out, p - 32'd4);

        // R3 jump target
        p = pc_out;
        run({6'h02, 26'h10});
        chk(pc_out == {p[31:28], 26'h10, 2'b00}, "R3 jump target", pc_out, {p[31:28], 26'h10, 2'b00});

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(pc_out == 32'd0, "R1 pc cleared by reset", pc_out, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule